// File: doc/BRIEF.md
# Unaligned Operand Access Splitter

This block sits between a load/store unit and a bus controller. It accepts one uncached or write-through operand access at a time. Each access has a byte address, a size (byte, word or long word), an instruction-fetch flag, a direction and write data. The block issues the shortest series of naturally aligned bus cycles that covers exactly the bytes of that operand.

Each piece is the widest size that is aligned at the current address and does not run past the end of the operand. Pieces are issued from the lowest address upward. The operand is big-endian, so its most significant byte sits at its lowest address.

On writes, the block steers each operand byte onto the bus byte lane selected by its address. On reads, it collects the returned lanes into a right-justified operand. It reports that operand with a one-cycle completion pulse. A misaligned instruction fetch is refused with an error pulse and produces no bus traffic.

Top module: `unaligned_access_splitter`

## Requirements
- R1: A byte access (size code 0) produces exactly one bus cycle of size code 0 at any value of address bits [1:0].
- R2: A word access (size code 1) produces one cycle of size code 1 at offsets 0 and 2, and two byte cycles at offsets 1 and 3.
- R3: A long-word access (size code 2; code 3 behaves the same) produces one cycle at offset 0. At offset 2 it produces two word cycles. At offsets 1 and 3 it produces three cycles sized byte, word, byte.
- R4: Pieces are issued in ascending address order. Each piece's bus_addr is the exact address of its first byte. A word piece always has address bit 0 clear, and a long piece has bits [1:0] clear.
- R5: On a write, bus_write is 1. The byte for address offset k is carried on bus_wdata[31-8k:24-8k]. The operand's most significant byte goes to its lowest address. Lanes outside the current piece are zero.
- R6: On a read, the byte found on lane k (same lane mapping as R5) at the piece covering address offset k is placed into rdata. rdata is right-justified, with the most significant operand byte coming from the lowest address and unused upper bits zero. done pulses for one cycle, in the cycle after the final piece is acknowledged.
- R7: bus_last is 1 on the final piece of an access and 0 on every other piece. bus_valid falls in the cycle after that piece is acknowledged.
- R8: While bus_valid is 1 and bus_ack is 0, bus_addr, bus_size and bus_wdata hold their values.
- R9: An instruction request with a nonzero offset produces an err pulse in the next cycle and no bus cycle. An instruction request at offset 0 produces exactly one cycle.
- R10: After reset, bus_valid, done and err are 0 and req_ready is 1.
- R11: req_ready is 0 while an access is in progress. A request presented then is ignored and does not alter the pieces still to be issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Access request, taken when req_ready is 1 |
| req_ready | output | 1 | Block is idle and can accept a request |
| req_addr | input | AW | Byte address of the operand |
| req_size | input | 2 | 0 byte, 1 word, 2 or 3 long word |
| req_instr | input | 1 | Request is an instruction fetch |
| req_write | input | 1 | 1 write, 0 read |
| req_wdata | input | DW | Write operand, right-justified |
| bus_valid | output | 1 | A bus piece is being presented |
| bus_addr | output | AW | Address of the first byte of the piece |
| bus_size | output | 2 | Piece size, 0 byte, 1 word, 2 long |
| bus_write | output | 1 | Direction of the piece |
| bus_wdata | output | DW | Write bytes on their address lanes |
| bus_last | output | 1 | Final piece of the access |
| bus_ack | input | 1 | Bus controller completes the piece |
| bus_rdata | input | DW | Read bytes on their address lanes |
| done | output | 1 | One-cycle pulse after the final acknowledge |
| rdata | output | DW | Assembled read operand, right-justified |
| err | output | 1 | One-cycle pulse for a misaligned instruction fetch |

## Verification
A wrong consumed-byte count shows up at the ports one cycle after an acknowledge. It appears as a wrong bus_addr, a wrong piece size, or write bytes on the wrong lanes. A wrong remaining count shows up as a misplaced bus_last, an extra piece or a missing piece. Gathering faults stay hidden until done and appear only in rdata. For that reason every read compares the full operand, and the bench compares every presented piece against a behavioural queue at every clock. Stalls are inserted at random points so that hold-state faults are exposed too.

// File: rtl/uas_pkg.sv
package uas_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_WORD = 2'd1,
      SZ_LONG = 2'd2
   } uas_size_e;

   // number of bytes carried by a size code (code 3 treated as long)
   function automatic logic [2:0] size_bytes(input logic [1:0] code);
      case (code)
         2'd0:    size_bytes = 3'd1;
         2'd1:    size_bytes = 3'd2;
         default: size_bytes = 3'd4;
      endcase
   endfunction

endpackage

// File: rtl/uas_piece_sel.sv
// Chooses the widest naturally aligned piece that fits the bytes left.
module uas_piece_sel #(
   parameter int NL = 4
) (
   input  logic [$clog2(NL)-1:0] off_i,
   input  logic [$clog2(NL):0]   left_i,
   output logic [$clog2(NL):0]   pbytes_o,
   output logic [1:0]            psize_o,
   output logic                  plast_o
);
   localparam int OW = $clog2(NL);
   localparam int CW = OW + 1;

   always_comb begin
      pbytes_o = CW'(1);
      psize_o  = 2'd0;
      for (int k = OW; k > 0; k--) begin
         if (pbytes_o == CW'(1) &&
             int'(left_i) >= (1 << k) &&
             (int'(off_i) & ((1 << k) - 1)) == 0) begin
            pbytes_o = CW'(1 << k);
            psize_o  = 2'(k);
         end
      end
      plast_o = (left_i == pbytes_o);
   end
endmodule

// File: rtl/uas_lane_pack.sv
// Steers big-endian operand bytes onto address-selected write lanes.
module uas_lane_pack #(
   parameter int DW = 32
) (
   input  logic [$clog2(DW/8)-1:0] off_i,
   input  logic [$clog2(DW/8):0]   used_i,
   input  logic [$clog2(DW/8):0]   nbytes_i,
   input  logic [$clog2(DW/8):0]   pbytes_i,
   input  logic [DW-1:0]           opnd_i,
   output logic [DW-1:0]           lanes_o
);
   localparam int NL = DW / 8;

   for (genvar L = 0; L < NL; L++) begin : g_lane
      logic [7:0] lane_b;
      always_comb begin
         int idx;
         int src;
         idx    = L - int'(off_i);
         src    = int'(nbytes_i) - 1 - int'(used_i) - idx;
         lane_b = 8'h00;
         if (idx >= 0 && idx < int'(pbytes_i) && src >= 0 && src < NL)
            lane_b = opnd_i[8*src +: 8];
      end
      assign lanes_o[DW-1-8*L -: 8] = lane_b;
   end
endmodule

// File: rtl/uas_gather.sv
// Collects read lanes into a right-justified operand.
module uas_gather #(
   parameter int DW = 32
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    clr_i,
   input  logic                    ack_i,
   input  logic                    last_i,
   input  logic [$clog2(DW/8)-1:0] off_i,
   input  logic [$clog2(DW/8):0]   used_i,
   input  logic [$clog2(DW/8):0]   nbytes_i,
   input  logic [$clog2(DW/8):0]   pbytes_i,
   input  logic [DW-1:0]           lanes_i,
   output logic [DW-1:0]           rdata_o
);
   localparam int NL = DW / 8;

   logic [DW-1:0] acc_q;
   logic [DW-1:0] acc_nxt;

   for (genvar K = 0; K < NL; K++) begin : g_byte
      logic [7:0] nb_b;
      always_comb begin
         int j;
         int li;
         j    = int'(nbytes_i) - 1 - K;
         li   = int'(off_i) + j - int'(used_i);
         nb_b = acc_q[8*K +: 8];
         if (j >= int'(used_i) && j < int'(used_i) + int'(pbytes_i) &&
             li >= 0 && li < NL)
            nb_b = lanes_i[DW-1-8*li -: 8];
      end
      assign acc_nxt[8*K +: 8] = nb_b;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q   <= '0;
         rdata_o <= '0;
      end else begin
         if (clr_i)      acc_q <= '0;
         else if (ack_i) acc_q <= acc_nxt;
         if (ack_i && last_i) rdata_o <= acc_nxt;
      end
   end
endmodule

// File: rtl/unaligned_access_splitter.sv
module unaligned_access_splitter
   import uas_pkg::*;
#(
   parameter int AW = 32,
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   output logic          req_ready,
   input  logic [AW-1:0] req_addr,
   input  logic [1:0]    req_size,
   input  logic          req_instr,
   input  logic          req_write,
   input  logic [DW-1:0] req_wdata,
   output logic          bus_valid,
   output logic [AW-1:0] bus_addr,
   output logic [1:0]    bus_size,
   output logic          bus_write,
   output logic [DW-1:0] bus_wdata,
   output logic          bus_last,
   input  logic          bus_ack,
   input  logic [DW-1:0] bus_rdata,
   output logic          done,
   output logic [DW-1:0] rdata,
   output logic          err
);
   localparam int NL = DW / 8;
   localparam int OW = $clog2(NL);
   localparam int CW = OW + 1;

   if (DW != 32) begin : g_bad_dw
      $error("unaligned_access_splitter: DW must be 32");
   end
   if (AW < 3) begin : g_bad_aw
      $error("unaligned_access_splitter: AW must be at least 3");
   end

   logic          busy_q;
   logic [AW-1:0] addr_q;
   logic [CW-1:0] nbytes_q;
   logic [CW-1:0] used_q;
   logic [DW-1:0] wdata_q;
   logic          write_q;
   logic          done_q;
   logic          err_q;

   logic          accept;
   logic          misfetch;
   logic [CW-1:0] left;
   logic [CW-1:0] pbytes;
   logic [1:0]    psize;
   logic          plast;
   logic          step;
   logic [CW-1:0] req_nbytes;

   assign accept     = req_valid && !busy_q;
   assign misfetch   = req_instr && (req_addr[OW-1:0] != '0);
   assign left       = nbytes_q - used_q;
   assign step       = busy_q && bus_ack;
   assign req_nbytes = CW'(size_bytes(req_size));

   uas_piece_sel #(.NL(NL)) i_sel (
      .off_i    (addr_q[OW-1:0]),
      .left_i   (left),
      .pbytes_o (pbytes),
      .psize_o  (psize),
      .plast_o  (plast)
   );

   uas_lane_pack #(.DW(DW)) i_pack (
      .off_i    (addr_q[OW-1:0]),
      .used_i   (used_q),
      .nbytes_i (nbytes_q),
      .pbytes_i (pbytes),
      .opnd_i   (wdata_q),
      .lanes_o  (bus_wdata)
   );

   uas_gather #(.DW(DW)) i_gather (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr_i    (accept && !misfetch),
      .ack_i    (step),
      .last_i   (plast),
      .off_i    (addr_q[OW-1:0]),
      .used_i   (used_q),
      .nbytes_i (nbytes_q),
      .pbytes_i (pbytes),
      .lanes_i  (bus_rdata),
      .rdata_o  (rdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q   <= 1'b0;
         addr_q   <= '0;
         nbytes_q <= '0;
         used_q   <= '0;
         wdata_q  <= '0;
         write_q  <= 1'b0;
         done_q   <= 1'b0;
         err_q    <= 1'b0;
      end else begin
         done_q <= 1'b0;
         err_q  <= 1'b0;
         if (accept) begin
            if (misfetch) begin
               err_q <= 1'b1;
            end else begin
               busy_q   <= 1'b1;
               addr_q   <= req_addr;
               nbytes_q <= req_nbytes;
               used_q   <= '0;
               wdata_q  <= req_wdata;
               write_q  <= req_write;
            end
         end else if (step) begin
            addr_q <= addr_q + AW'(pbytes);
            used_q <= used_q + pbytes;
            if (plast) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
            end
         end
      end
   end

   assign req_ready = !busy_q;
   assign bus_valid = busy_q;
   assign bus_addr  = addr_q;
   assign bus_size  = psize;
   assign bus_write = write_q;
   assign bus_last  = plast;
   assign done      = done_q;
   assign err       = err_q;

   // R8: presented piece is frozen until acknowledged
   a_r8_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
      bus_valid && !bus_ack |=> bus_valid && $stable(bus_addr) &&
                                $stable(bus_size) && $stable(bus_wdata));

   // R4: word pieces even, long pieces on a four-byte boundary
   a_r4_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      bus_valid && bus_size != 2'd0 |-> bus_addr[0] == 1'b0);
   a_r4_long_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      bus_valid && bus_size == 2'd2 |-> bus_addr[1:0] == 2'b00);

   // R4: next piece starts right after the acknowledged one
   a_r4_ascending: assert property (@(posedge clk) disable iff (!rst_n)
      bus_valid && bus_ack && !bus_last |=>
         bus_valid && bus_addr == $past(bus_addr) + AW'(size_bytes($past(bus_size))));

   // R7: acknowledging the final piece ends the bus activity
   a_r7_last_ends: assert property (@(posedge clk) disable iff (!rst_n)
      bus_valid && bus_ack && bus_last |=> !bus_valid && done);

   // R6: done only follows an acknowledged final piece
   a_r6_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(bus_valid && bus_ack && bus_last));

   // R9: refused fetch produces no bus piece
   a_r9_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> !bus_valid && !done);
endmodule

// File: tb/test_unaligned_access_splitter.sv
`timescale 1ns/1ps
module test_unaligned_access_splitter;
   localparam int AW = 32;
   localparam int DW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic [AW-1:0] req_addr = '0;
   logic [1:0]    req_size = '0;
   logic          req_instr = 1'b0;
   logic          req_write = 1'b0;
   logic [DW-1:0] req_wdata = '0;
   logic          bus_valid;
   logic [AW-1:0] bus_addr;
   logic [1:0]    bus_size;
   logic          bus_write;
   logic [DW-1:0] bus_wdata;
   logic          bus_last;
   logic          bus_ack = 1'b0;
   logic [DW-1:0] bus_rdata;
   logic          done;
   logic [DW-1:0] rdata;
   logic          err;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   unaligned_access_splitter #(.AW(AW), .DW(DW)) i_unaligned_access_splitter (.*);

   function automatic logic [7:0] mem_byte(input logic [31:0] a);
      return 8'(a * 37 + 11);
   endfunction

   // slave memory: all four lanes of the addressed aligned word
   always_comb begin
      for (int l = 0; l < 4; l++)
         bus_rdata[31-8*l -: 8] = mem_byte({bus_addr[31:2], 2'(l)});
   end

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic report();
      if (!finished) begin
         finished = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   task automatic run(input logic [31:0] addr, input int szc, input bit instr,
                      input bit wr, input logic [31:0] wd, input string tag, input bit poke);
      logic [31:0] qa[$];
      int          qs[$];
      logic [31:0] qw[$];
      logic [31:0] a, w, exp_rd;
      int          nb, n, c, p, cyc;
      bit          ack, first, prev_ack;
      string       stag;
      nb = (szc == 0) ? 1 : (szc == 1) ? 2 : 4;
      a = addr; n = nb; c = 0;
      while (n > 0) begin
         p = (n >= 4 && a[1:0] == 2'd0) ? 4 : (n >= 2 && a[0] == 1'b0) ? 2 : 1;
         w = '0;
         for (int i = 0; i < p; i++)
            w[8*(3 - (int'(a[1:0]) + i)) +: 8] = wd[8*(nb - 1 - c - i) +: 8];
         qa.push_back(a); qs.push_back(p); qw.push_back(w);
         a += 32'(p); c += p; n -= p;
      end
      exp_rd = '0;
      for (int j = 0; j < nb; j++) exp_rd[8*(nb - 1 - j) +: 8] = mem_byte(addr + 32'(j));
      stag = instr ? "R9" : tag;

      @(negedge clk);
      while (!req_ready) @(negedge clk);
      chk("R11 ready when idle", req_ready, 1);
      req_valid = 1; req_addr = addr; req_size = 2'(szc); req_instr = instr;
      req_write = wr; req_wdata = wd;
      @(negedge clk);
      req_valid = 0;

      if (instr && addr[1:0] != 2'd0) begin
         chk("R9 err pulse", err, 1);
         chk("R9 no bus piece", bus_valid, 0);
         @(negedge clk);
         chk("R9 err one cycle", err, 0);
         chk("R9 still no piece", bus_valid, 0);
         return;
      end

      first = 1; cyc = 0; prev_ack = 1;
      while (qa.size() > 0) begin
         chk("R4 piece present", bus_valid, 1);
         chk(prev_ack ? "R4 address" : "R8 address held", bus_addr, qa[0]);
         chk({stag, " piece size"}, bus_size, (qs[0] == 1) ? 0 : (qs[0] == 2) ? 1 : 2);
         chk("R7 last flag", bus_last, qa.size() == 1);
         chk("R5 direction", bus_write, wr);
         if (wr) chk(prev_ack ? "R5 write lanes" : "R8 write lanes held", bus_wdata, qw[0]);
         chk("R6 no early done", done, 0);
         chk("R11 not ready while busy", req_ready, 0);
         if (poke && first) begin
            req_valid = 1; req_addr = 32'h0000_0055; req_size = 2'd0;
            req_write = ~wr; req_wdata = 32'hDEAD_BEEF;
            ack = 0;
         end else begin
            req_valid = 0;
            ack = ($urandom % 3) != 0;
         end
         first = 0;
         bus_ack = ack;
         @(negedge clk);
         bus_ack = 0;
         prev_ack = ack;
         if (ack) begin
            void'(qa.pop_front()); void'(qs.pop_front()); void'(qw.pop_front());
         end
         cyc++;
         if (cyc > 200) begin
            chk("R6 access completes", 0, 1);
            qa.delete();
         end
      end
      req_valid = 0;
      chk("R6 done pulse", done, 1);
      chk("R7 bus idle after last", bus_valid, 0);
      if (!wr) chk({tag, "/R6 read operand"}, rdata, exp_rd);
      @(negedge clk);
      chk("R6 done one cycle", done, 0);
      chk("R11 no extra piece", bus_valid, 0);
   endtask

   initial begin
      #1_000_000;
      chk("watchdog", 0, 1);
      report();
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R10 bus_valid reset", bus_valid, 0);
      chk("R10 done reset", done, 0);
      chk("R10 err reset", err, 0);
      chk("R10 ready reset", req_ready, 1);
      rst_n = 1;
      @(negedge clk);

      for (int o = 0; o < 4; o++) begin
         run(32'h0000_1000 + 32'(o), 0, 0, 0, 32'h0, "R1", 0);
         run(32'h0000_2000 + 32'(o), 0, 0, 1, 32'h0000_00A5, "R1", 0);
         run(32'h0000_3000 + 32'(o), 1, 0, 0, 32'h0, "R2", 0);
         run(32'h0000_3100 + 32'(o), 1, 0, 1, 32'h0000_BEEF, "R2", 0);
         run(32'h0000_4000 + 32'(o), 2, 0, 0, 32'h0, "R3", 0);
         run(32'h0000_4100 + 32'(o), 2, 0, 1, 32'h1234_5678, "R3", 0);
         run(32'h0000_5000 + 32'(o), 2, 1, 0, 32'h0, "R9", 0);
      end
      run(32'h0000_10FF, 2, 0, 1, 32'hCAFE_F00D, "R3", 0);
      run(32'h0000_10FD, 2, 0, 0, 32'h0, "R3", 0);
      run(32'h0000_6001, 2, 0, 1, 32'hA1B2_C3D4, "R3", 1);
      run(32'h0000_6003, 1, 0, 0, 32'h0, "R2", 1);
      for (int t = 0; t < 60; t++) begin
         int sz;
         sz = $urandom % 3;
         run($urandom, sz, ($urandom % 8) == 0, $urandom % 2, $urandom,
             (sz == 0) ? "R1" : (sz == 1) ? "R2" : "R3", ($urandom % 5) == 0);
      end
      repeat (2) @(negedge clk);
      report();
   end
endmodule